// File: doc/BRIEF.md
# Keyed Region Access Guard

This block judges whether a read or write request to a small tag memory may proceed. The memory has 128 bytes, split into four regions of 32 bytes. Two access keys, each with its own right for every region, are held at the same time. Each request carries a key. The guard compares that key with both stored keys. It then looks up the right for the addressed region and returns grant or deny, together with an error code that a status reply can carry.

The stored keys and the rights table come from a reserved security area. Some other agent reads that area and presents it on the configuration inputs. The first cycle in which `cfg_valid` is high after reset loads the configuration into registers. Until that happens, every request is refused. Requests use a ready/valid handshake. The decision is registered and appears exactly one clock after the request is accepted. `mem_wr_en` is the memory write strobe. It is raised only for a granted write.

Top module: `tag_access_guard`

## Requirements
- R1: The addressed region is the top two bits of the 7-bit byte address (region r covers addresses 32*r to 32*r+31). Rights are judged per region only.
- R2: Each key has an 8-bit rights field. The 2-bit code for region r sits at bits [2r+1:2r]. Code 00 means no access, 01 means read only, 11 means read and write, and 10 is treated as no access.
- R3: A request whose key equals neither stored key is denied with error code 01.
- R4: A request whose operation is not allowed by the right of a matching key for the addressed region is denied with error code 10. A read needs 01 or 11. A write needs 11.
- R5: When both stored keys match the presented key, an operation is allowed if either key's right allows it.
- R6: The configuration is captured on the first clock edge at which `cfg_valid` is high after reset. Later values on the configuration inputs have no effect until the next reset.
- R7: Before the configuration is captured, every accepted request is denied with error code 11.
- R8: `req_ready` is low during reset and high from the first clock edge after reset is released. `rsp_valid` is high in exactly the cycle after each accepted request (`req_valid` and `req_ready` both high at an edge), and low otherwise.
- R9: While `rsp_valid` is high, exactly one of `rsp_grant` and `rsp_deny` is high. A grant carries error code 00. A deny carries a nonzero code. All three are low when `rsp_valid` is low.
- R10: `mem_wr_en` is high only in the response cycle of a granted write. It is never high for a denied request or for a read.
- R11: During reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_valid | input | 1 | Configuration inputs hold valid security-area contents |
| cfg_keys | input | 32 | Stored keys, key 0 in bits [15:0], key 1 in bits [31:16] |
| cfg_rights | input | 16 | Rights fields, key 0 in bits [7:0], key 1 in bits [15:8] |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Guard accepts a request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 7 | Byte address |
| req_key | input | 16 | Key presented with the request |
| rsp_valid | output | 1 | Decision valid |
| rsp_grant | output | 1 | Access granted |
| rsp_deny | output | 1 | Access refused |
| rsp_err | output | 2 | 00 none, 01 no key match, 10 insufficient right, 11 not configured |
| mem_wr_en | output | 1 | Write strobe for a granted write |

## Verification
The bench probes the first and last byte of each region. A design that took the region from the wrong address bits would grant or refuse at the wrong edge. Code 10 is tested in its own region, so a design that read only the low bit would deny a read where it should, but code 01 must still allow reads without writes. A second configuration gives both keys the same value with different rights. A design that let only the first matching key decide would wrongly refuse the write that the second key permits. The bench also changes the configuration inputs after the configuration has been captured, and sends requests before any configuration. These catch a design that reloads the configuration or that decides with zeroed keys.

// File: rtl/tag_acc_pkg.sv
package tag_acc_pkg;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'b00,
    ERR_AUTH   = 2'b01,
    ERR_RIGHTS = 2'b10,
    ERR_UNCFG  = 2'b11
  } acc_err_e;

  // read permitted for codes 01 and 11
  function automatic logic right_allows_read(input logic [1:0] code);
    return code[0];
  endfunction

  // write permitted only for code 11; 10 counts as no access
  function automatic logic right_allows_write(input logic [1:0] code);
    return code == 2'b11;
  endfunction

endpackage

// File: rtl/acc_cfg_store.sv
module acc_cfg_store #(
  parameter int KEY_W    = 16,
  parameter int NUM_KEYS = 2,
  parameter int RIGHTS_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_valid,
  input  logic [NUM_KEYS*KEY_W-1:0]    cfg_keys,
  input  logic [NUM_KEYS*RIGHTS_W-1:0] cfg_rights,
  output logic [NUM_KEYS*KEY_W-1:0]    keys_q,
  output logic [NUM_KEYS*RIGHTS_W-1:0] rights_q,
  output logic                         loaded_q
);

  logic capture;
  assign capture = cfg_valid && !loaded_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keys_q   <= '0;
      rights_q <= '0;
      loaded_q <= 1'b0;
    end else if (capture) begin
      keys_q   <= cfg_keys;
      rights_q <= cfg_rights;
      loaded_q <= 1'b1;
    end
  end

endmodule

// File: rtl/acc_key_match.sv
module acc_key_match #(
  parameter int KEY_W    = 16,
  parameter int NUM_KEYS = 2
) (
  input  logic [NUM_KEYS*KEY_W-1:0] keys,
  input  logic [KEY_W-1:0]          req_key,
  output logic [NUM_KEYS-1:0]       hit
);

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_cmp
    assign hit[k] = (keys[k*KEY_W +: KEY_W] == req_key);
  end

endmodule

// File: rtl/acc_rights_merge.sv
module acc_rights_merge
  import tag_acc_pkg::*;
#(
  parameter int NUM_KEYS    = 2,
  parameter int NUM_REGIONS = 4,
  parameter int REG_IDX_W   = 2,
  parameter int RIGHTS_W    = 2 * NUM_REGIONS
) (
  input  logic [NUM_KEYS*RIGHTS_W-1:0] rights,
  input  logic [NUM_KEYS-1:0]          hit,
  input  logic [REG_IDX_W-1:0]         region,
  output logic                         rd_ok,
  output logic                         wr_ok
);

  logic [NUM_KEYS-1:0][1:0] code;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_lookup
    assign code[k] = rights[k*RIGHTS_W + 2*int'(region) +: 2];
  end

  // the most permissive right among matching keys wins
  always_comb begin
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    for (int k = 0; k < NUM_KEYS; k++) begin
      if (hit[k]) begin
        rd_ok = rd_ok | right_allows_read(code[k]);
        wr_ok = wr_ok | right_allows_write(code[k]);
      end
    end
  end

endmodule

// File: rtl/tag_access_guard.sv
module tag_access_guard
  import tag_acc_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int KEY_W       = 16,
  parameter int NUM_KEYS    = 2,
  parameter int NUM_REGIONS = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_valid,
  input  logic [NUM_KEYS*KEY_W-1:0]         cfg_keys,
  input  logic [NUM_KEYS*2*NUM_REGIONS-1:0] cfg_rights,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic                              req_write,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [KEY_W-1:0]                  req_key,
  output logic                              rsp_valid,
  output logic                              rsp_grant,
  output logic                              rsp_deny,
  output logic [1:0]                        rsp_err,
  output logic                              mem_wr_en
);

  localparam int REG_IDX_W = $clog2(NUM_REGIONS);
  localparam int RIGHTS_W  = 2 * NUM_REGIONS;

  logic [NUM_KEYS*KEY_W-1:0]    keys_q;
  logic [NUM_KEYS*RIGHTS_W-1:0] rights_q;
  logic                         cfg_loaded;
  logic [NUM_KEYS-1:0]          key_hit;
  logic [REG_IDX_W-1:0]         region;
  logic                         rd_ok, wr_ok;
  logic                         fire;
  acc_err_e                     dec_err;
  acc_err_e                     err_q;
  logic                         unused_addr_bits;

  assign region           = req_addr[ADDR_W-1 -: REG_IDX_W];
  assign unused_addr_bits = ^req_addr[ADDR_W-REG_IDX_W-1:0];
  assign fire             = req_valid && req_ready;

  acc_cfg_store #(.KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS), .RIGHTS_W(RIGHTS_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_keys  (cfg_keys),
    .cfg_rights(cfg_rights),
    .keys_q    (keys_q),
    .rights_q  (rights_q),
    .loaded_q  (cfg_loaded)
  );

  acc_key_match #(.KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS)) u_match (
    .keys   (keys_q),
    .req_key(req_key),
    .hit    (key_hit)
  );

  acc_rights_merge #(
    .NUM_KEYS(NUM_KEYS), .NUM_REGIONS(NUM_REGIONS),
    .REG_IDX_W(REG_IDX_W), .RIGHTS_W(RIGHTS_W)
  ) u_merge (
    .rights(rights_q),
    .hit   (key_hit),
    .region(region),
    .rd_ok (rd_ok),
    .wr_ok (wr_ok)
  );

  always_comb begin
    dec_err = ERR_NONE;
    if (!cfg_loaded)
      dec_err = ERR_UNCFG;
    else if (key_hit == '0)
      dec_err = ERR_AUTH;
    else if (req_write ? !wr_ok : !rd_ok)
      dec_err = ERR_RIGHTS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_ready <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_deny  <= 1'b0;
      err_q     <= ERR_NONE;
      mem_wr_en <= 1'b0;
    end else begin
      req_ready <= 1'b1;
      rsp_valid <= fire;
      rsp_grant <= fire && (dec_err == ERR_NONE);
      rsp_deny  <= fire && (dec_err != ERR_NONE);
      err_q     <= fire ? dec_err : ERR_NONE;
      mem_wr_en <= fire && req_write && (dec_err == ERR_NONE);
    end
  end

  assign rsp_err = err_q;

endmodule

// File: rtl/tag_access_guard_chk.sv
module tag_access_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fire,
  input logic       cfg_loaded,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_grant,
  input logic       rsp_deny,
  input logic [1:0] rsp_err,
  input logic       mem_wr_en
);

  // R8
  accept_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  // R8
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !rsp_valid);

  // R9
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_grant, rsp_deny}));

  // R9
  grant_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_grant |-> rsp_err == 2'b00);

  // R9
  deny_coded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_deny |-> rsp_err != 2'b00);

  // R10
  strobe_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> rsp_grant);

  // R7
  uncfg_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cfg_loaded) |=> (rsp_deny && rsp_err == 2'b11));

  // R6
  cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_loaded |=> cfg_loaded);

  // R8
  ready_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready);

endmodule

bind tag_access_guard tag_access_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fire      (fire),
  .cfg_loaded(cfg_loaded),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_grant (rsp_grant),
  .rsp_deny  (rsp_deny),
  .rsp_err   (rsp_err),
  .mem_wr_en (mem_wr_en)
);

// File: tb/tag_access_guard_tb.sv
module tag_access_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [31:0] cfg_keys = '0;
  logic [15:0] cfg_rights = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [15:0] req_key = '0;
  logic        rsp_valid, rsp_grant, rsp_deny, mem_wr_en;
  logic [1:0]  rsp_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  tag_access_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_keys(cfg_keys),
    .cfg_rights(cfg_rights), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_key(req_key),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_deny(rsp_deny),
    .rsp_err(rsp_err), .mem_wr_en(mem_wr_en)
  );

  localparam logic [1:0] E_NONE = 2'b00, E_AUTH = 2'b01, E_RGT = 2'b10, E_UNC = 2'b11;
  localparam logic [15:0] KA = 16'hA5A5, KB = 16'h3C3C;

  // {write, addr, key, expected grant, expected error}
  localparam int NV = 13;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 7'h00, KA,       1'b1, E_NONE},  // R1 region 0 first byte, read
    {1'b1, 7'h1F, KA,       1'b1, E_NONE},  // R2 region 0 last byte, 11 write
    {1'b0, 7'h20, KA,       1'b1, E_NONE},  // R2 code 01 read
    {1'b1, 7'h3F, KA,       1'b0, E_RGT},   // R4 code 01 write refused
    {1'b0, 7'h40, KA,       1'b0, E_RGT},   // R4 code 00 read
    {1'b1, 7'h45, KA,       1'b0, E_RGT},   // R4 code 00 write
    {1'b0, 7'h60, KA,       1'b0, E_RGT},   // R2 code 10 read is none
    {1'b1, 7'h7F, KA,       1'b0, E_RGT},   // R2 code 10 write is none
    {1'b1, 7'h60, KB,       1'b1, E_NONE},  // R1 other key, all regions open
    {1'b0, 7'h40, KB,       1'b1, E_NONE},
    {1'b1, 7'h20, KB,       1'b1, E_NONE},
    {1'b0, 7'h00, 16'h1234, 1'b0, E_AUTH},  // R3
    {1'b1, 7'h00, 16'h1234, 1'b0, E_AUTH}   // R3
  };

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] rsp_bus();
    return {rsp_valid, rsp_grant, rsp_deny, rsp_err, mem_wr_en};
  endfunction

  task automatic do_req(input logic wr, input logic [6:0] a, input logic [15:0] k,
                        input logic g, input logic [1:0] e, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_key = k;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, rsp_bus(), {1'b1, g, ~g, e, wr & g});
  endtask

  task automatic load_cfg(input logic [31:0] k, input logic [15:0] r);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_keys = k; cfg_rights = r;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 outputs low in reset
    check("R11", {req_ready, rsp_bus()[5:1], mem_wr_en}, 6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 ready after first edge out of reset
    check("R8", {5'b0, req_ready}, 6'b000001);

    // R7 before configuration
    do_req(1'b0, 7'h00, 16'h0000, 1'b0, E_UNC, "R7 read unconfigured");
    do_req(1'b1, 7'h10, 16'h0000, 1'b0, E_UNC, "R7 write unconfigured");
    @(negedge clk);
    check("R8 idle", rsp_bus(), 6'b0);

    // key0 rights {r3,r2,r1,r0} = 10 00 01 11, key1 all 11
    load_cfg({KB, KA}, {8'hFF, 8'h87});
    for (int i = 0; i < NV; i++) begin
      do_req(VEC[i][26], VEC[i][25:19], VEC[i][18:3], VEC[i][2], VEC[i][1:0],
             $sformatf("R1/R2/R3/R4 vector %0d", i));
    end

    // R6 later configuration ignored
    load_cfg({16'h9999, 16'h9999}, {8'hFF, 8'hFF});
    do_req(1'b0, 7'h00, 16'h9999, 1'b0, E_AUTH, "R6 new key ignored");
    do_req(1'b1, 7'h40, KA, 1'b0, E_RGT, "R6 old rights kept");

    // R6 reset clears configuration
    do_reset();
    @(negedge clk);
    do_req(1'b0, 7'h00, KA, 1'b0, E_UNC, "R6 R7 after reset");

    // R5 both keys equal: key0 region0 = 01, key1 region1 = 11
    load_cfg({16'h7777, 16'h7777}, {8'h0C, 8'h01});
    do_req(1'b1, 7'h00, 16'h7777, 1'b0, E_RGT,  "R5 write region0");
    do_req(1'b0, 7'h00, 16'h7777, 1'b1, E_NONE, "R5 read region0");
    do_req(1'b1, 7'h20, 16'h7777, 1'b1, E_NONE, "R5 write region1 via second key");
    do_req(1'b0, 7'h40, 16'h7777, 1'b0, E_RGT,  "R5 read region2");
    @(negedge clk);
    check("R10 idle", rsp_bus(), 6'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule